// File: doc/BRIEF.md
# Dataflow Grid Execution Tile

This block is a single tile of a two-dimensional array of ALUs. It holds a small store of instructions that are placed into fixed slots ahead of time and fired at run time in dataflow order. Each slot keeps an opcode, two operand buffers, a block (frame) tag and up to two consumer targets. A slot fires as soon as every operand its opcode needs has arrived. The ALU result then leaves the tile as one packet per target. Each packet names the consumer by a signed row and column offset from this tile, a slot index and an operand position.

Operands are pushed straight into named slots, so the tile has no register read, no renaming and no associative wakeup. Several blocks can be resident together because each slot carries a frame tag. A mispredicted block is discarded by one squash that clears every slot carrying its tag. Block inputs come in through move instructions. A move forwards OP1 unchanged and can fan it out to two consumers.

Top module: `dgrid_node`

## Requirements
- R1: After reset every slot is empty, `res_valid` is low and `op_err` is low.
- R2: A load writes opcode, frame tag, target count and both targets into the addressed slot. It marks the slot occupied with both operands absent, and it replaces whatever the slot held before.
- R3: An operand sent to an occupied slot, for a position that the opcode uses and that is still absent, is stored. Position 0 is OP1 and position 1 is OP2.
- R4: A slot is ready when it is occupied, OP1 is present, and OP2 is present or the opcode is a move. Ready slots do not all fire at once: at most one fires per clock edge, and the lowest-numbered one is chosen. The fired slot becomes empty. Its first packet is visible right after the edge at which it fires, which is the edge after its last operand was accepted.
- R5: Opcode 0 adds, 1 subtracts (OP1 minus OP2), 2 is AND, 3 is OR, 4 is XOR, and 5 to 7 are moves that forward OP1. All results are modulo 2^32.
- R6: A target is a vector packed as {row offset, column offset, slot, position} with the row in the top bits. The offsets are two's complement. A target count of 0 sends no packet. A count of 1 sends target 0 only. A count of 2 or 3 sends target 0 and then target 1 on the next edge, and no slot fires at the edge that sends the second packet.
- R7: A squash empties, at the next edge, every slot whose frame tag equals the squash tag. A slot of that frame that is ready in the same cycle does not fire. A pending second packet of that frame is dropped.
- R8: An operand arriving in the same cycle as a squash that hits its occupied slot is dropped without raising `op_err`.
- R9: An operand is rejected and `op_err` is high for the cycle after the edge in three cases: the slot is empty, the position is already present, or the position is OP2 of a move. A rejected operand leaves the stored operand values untouched.
- R10: A load takes effect even in the same cycle as a squash of its own frame, and even in the same cycle as the old occupant of that slot firing. In the second case the old instruction still fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load an instruction this cycle |
| ld_slot | input | SLW | Slot to load |
| ld_opc | input | 3 | Opcode |
| ld_frame | input | FW | Frame tag of the instruction |
| ld_ntgt | input | 2 | Number of targets (0..3, 3 acts as 2) |
| ld_tgt0 | input | TGW | First target {row, col, slot, pos} |
| ld_tgt1 | input | TGW | Second target |
| op_en | input | 1 | Operand delivery valid |
| op_slot | input | SLW | Destination slot of the operand |
| op_pos | input | 1 | 0 = OP1, 1 = OP2 |
| op_data | input | W | Operand value |
| sq_en | input | 1 | Squash request |
| sq_frame | input | FW | Frame tag to squash |
| res_valid | output | 1 | Result packet valid |
| res_data | output | W | Result value |
| res_row | output | OW | Signed row offset of consumer |
| res_col | output | OW | Signed column offset of consumer |
| res_slot | output | SLW | Consumer slot |
| res_pos | output | 1 | Consumer operand position |
| op_err | output | 1 | Rejected operand, one cycle after delivery |

## Verification
The tightest collisions are between squash and firing. A squash is driven in exactly the cycle in which a slot of the same frame has just become ready, and also in the cycle in which a two-target instruction of that frame owes its second packet. The outcome is judged by whether a packet appears and by which lower-priority slot of another frame fires instead. Operand delivery is also overlapped with a squash of the same slot, and loads are overlapped with squashes and with the firing of the slot being overwritten. A behavioural model in the bench decides the expected packet stream and error pulses cycle by cycle.

// File: rtl/dgrid_node.sv
`timescale 1ns/1ps
module dgrid_node #(
  parameter int SLOTS = 32,
  parameter int W = 32,
  parameter int FW = 2,
  parameter int OW = 3,
  localparam int SLW = $clog2(SLOTS),
  localparam int TGW = 2*OW + SLW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_en,
  input  logic [SLW-1:0] ld_slot,
  input  logic [2:0]     ld_opc,
  input  logic [FW-1:0]  ld_frame,
  input  logic [1:0]     ld_ntgt,
  input  logic [TGW-1:0] ld_tgt0,
  input  logic [TGW-1:0] ld_tgt1,
  input  logic           op_en,
  input  logic [SLW-1:0] op_slot,
  input  logic           op_pos,
  input  logic [W-1:0]   op_data,
  input  logic           sq_en,
  input  logic [FW-1:0]  sq_frame,
  output logic           res_valid,
  output logic [W-1:0]   res_data,
  output logic [OW-1:0]  res_row,
  output logic [OW-1:0]  res_col,
  output logic [SLW-1:0] res_slot,
  output logic           res_pos,
  output logic           op_err
);

  logic [SLOTS-1:0] vld, p1, p2, sq_hit, rdy;
  logic [SLOTS-1:0] vld_n, p1_n, p2_n, clr;
  logic [2:0]     opc [SLOTS];
  logic [FW-1:0]  frm [SLOTS];
  logic [1:0]     nt  [SLOTS];
  logic [TGW-1:0] t0  [SLOTS];
  logic [TGW-1:0] t1  [SLOTS];
  logic [W-1:0]   a   [SLOTS];
  logic [W-1:0]   b   [SLOTS];

  logic           pend_v;
  logic [FW-1:0]  pend_frm;
  logic [TGW-1:0] pend_tgt, res_tgt;
  logic [W-1:0]   pend_data, alu;
  logic [SLW-1:0] sel;
  logic           any, issue;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_slot
      assign sq_hit[g] = sq_en && (frm[g] == sq_frame);
      assign rdy[g]    = vld[g] && p1[g] && (p2[g] || opc[g] >= 3'd5) && !sq_hit[g];
    end
  endgenerate

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = SLOTS-1; i >= 0; i--)
      if (rdy[i]) begin
        sel = SLW'(i);
        any = 1'b1;
      end
  end
  assign issue = any && !pend_v;

  always_comb begin
    case (opc[sel])
      3'd0:    alu = a[sel] + b[sel];
      3'd1:    alu = a[sel] - b[sel];
      3'd2:    alu = a[sel] & b[sel];
      3'd3:    alu = a[sel] | b[sel];
      3'd4:    alu = a[sel] ^ b[sel];
      default: alu = a[sel];
    endcase
  end

  logic op_full, op_hit, op_ok, op_bad, op_mv;
  assign op_mv   = opc[op_slot] >= 3'd5;
  assign op_full = op_pos ? p2[op_slot] : p1[op_slot];
  assign op_hit  = sq_hit[op_slot] && vld[op_slot];
  assign op_ok   = op_en && vld[op_slot] && !op_full && !(op_pos && op_mv) && !op_hit;
  assign op_bad  = op_en && !op_ok && !op_hit;

  always_comb begin
    clr = sq_hit;
    if (issue) clr[sel] = 1'b1;
    vld_n = vld & ~clr;
    p1_n  = p1 & ~clr;
    p2_n  = p2 & ~clr;
    if (op_ok) begin
      if (op_pos) p2_n[op_slot] = 1'b1;
      else        p1_n[op_slot] = 1'b1;
    end
    if (ld_en) begin
      vld_n[ld_slot] = 1'b1;
      p1_n[ld_slot]  = 1'b0;
      p2_n[ld_slot]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= '0;
      p1        <= '0;
      p2        <= '0;
      pend_v    <= 1'b0;
      pend_frm  <= '0;
      pend_tgt  <= '0;
      pend_data <= '0;
      res_valid <= 1'b0;
      res_tgt   <= '0;
      res_data  <= '0;
      op_err    <= 1'b0;
    end else begin
      vld    <= vld_n;
      p1     <= p1_n;
      p2     <= p2_n;
      op_err <= op_bad;
      if (pend_v) begin
        res_valid <= !(sq_en && pend_frm == sq_frame);
        res_tgt   <= pend_tgt;
        res_data  <= pend_data;
        pend_v    <= 1'b0;
      end else if (issue) begin
        res_valid <= nt[sel] != 2'd0;
        res_tgt   <= t0[sel];
        res_data  <= alu;
        pend_v    <= nt[sel][1];
        pend_tgt  <= t1[sel];
        pend_frm  <= frm[sel];
        pend_data <= alu;
      end else begin
        res_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      opc[ld_slot] <= ld_opc;
      frm[ld_slot] <= ld_frame;
      nt[ld_slot]  <= ld_ntgt;
      t0[ld_slot]  <= ld_tgt0;
      t1[ld_slot]  <= ld_tgt1;
    end
    if (op_ok) begin
      if (op_pos) b[op_slot] <= op_data;
      else        a[op_slot] <= op_data;
    end
  end

  assign {res_row, res_col, res_slot, res_pos} = res_tgt;

endmodule

module dgrid_node_chk #(
  parameter int SLOTS = 32,
  parameter int FW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_en,
  input logic             sq_en,
  input logic             op_en,
  input logic             op_err,
  input logic             res_valid,
  input logic             pend_v,
  input logic [SLOTS-1:0] vld,
  input logic [SLOTS-1:0] p1,
  input logic [SLOTS-1:0] p2,
  input logic [SLOTS-1:0] sq_hit
);

  // R3
  present_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((p1 | p2) & ~vld) == '0);

  // R4
  single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !sq_en) |=> ($countones(vld) + 1 >= $past($countones(vld))));

  // R6
  second_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !sq_en) |=> res_valid);

  // R7
  squash_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_en && !ld_en) |=> ((vld & $past(sq_hit)) == '0));

  // R9
  err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> $past(op_en));

endmodule

bind dgrid_node dgrid_node_chk #(.SLOTS(SLOTS), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .sq_en(sq_en), .op_en(op_en),
  .op_err(op_err), .res_valid(res_valid), .pend_v(pend_v),
  .vld(vld), .p1(p1), .p2(p2), .sq_hit(sq_hit)
);

// File: tb/dgrid_node_bench.sv
`timescale 1ns/1ps
module dgrid_node_bench;
  localparam int SLOTS = 32;
  localparam int W = 32;
  localparam int FW = 2;
  localparam int OW = 3;
  localparam int SLW = $clog2(SLOTS);
  localparam int TGW = 2*OW + SLW + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_en = 0, op_en = 0, op_pos = 0, sq_en = 0;
  logic [SLW-1:0] ld_slot = '0, op_slot = '0;
  logic [2:0] ld_opc = '0;
  logic [FW-1:0] ld_frame = '0, sq_frame = '0;
  logic [1:0] ld_ntgt = '0;
  logic [TGW-1:0] ld_tgt0 = '0, ld_tgt1 = '0;
  logic [W-1:0] op_data = '0;
  logic res_valid, res_pos, op_err;
  logic [W-1:0] res_data;
  logic [OW-1:0] res_row, res_col;
  logic [SLW-1:0] res_slot;

  dgrid_node u_dgrid_node (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit running = 0, done = 0;
  string cur_req = "R1";

  bit m_v[SLOTS], m_p1[SLOTS], m_p2[SLOTS];
  int m_op[SLOTS], m_fr[SLOTS], m_nt[SLOTS];
  logic [TGW-1:0] m_t0[SLOTS], m_t1[SLOTS];
  logic [31:0] m_a[SLOTS], m_b[SLOTS];
  bit mp_v; int mp_fr; logic [TGW-1:0] mp_t; logic [31:0] mp_d;
  bit e_valid = 0, e_err = 0;
  logic [TGW-1:0] e_tgt = '0;
  logic [31:0] e_data = '0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int s, win;
    bit drop, err, acc;
    logic [31:0] r;
    s = int'(op_slot);
    drop = 0; err = 0; acc = 0; win = -1; r = '0;
    if (op_en) begin
      if (m_v[s] && sq_en && m_fr[s] == int'(sq_frame)) drop = 1;
      else if (!m_v[s] || (op_pos ? m_p2[s] : m_p1[s]) || (op_pos && m_op[s] >= 5)) err = 1;
      else acc = 1;
    end
    if (mp_v) begin
      e_valid = !(sq_en && mp_fr == int'(sq_frame));
      e_tgt = mp_t; e_data = mp_d; mp_v = 0;
    end else begin
      for (int i = 0; i < SLOTS; i++)
        if (win < 0 && m_v[i] && m_p1[i] && (m_p2[i] || m_op[i] >= 5) &&
            !(sq_en && m_fr[i] == int'(sq_frame))) win = i;
      if (win >= 0) begin
        case (m_op[win])
          0: r = m_a[win] + m_b[win];
          1: r = m_a[win] - m_b[win];
          2: r = m_a[win] & m_b[win];
          3: r = m_a[win] | m_b[win];
          4: r = m_a[win] ^ m_b[win];
          default: r = m_a[win];
        endcase
        e_valid = m_nt[win] != 0;
        e_tgt = m_t0[win]; e_data = r;
        if (m_nt[win] >= 2) begin
          mp_v = 1; mp_t = m_t1[win]; mp_fr = m_fr[win]; mp_d = r;
        end
      end else e_valid = 0;
    end
    e_err = err;
    if (sq_en)
      for (int i = 0; i < SLOTS; i++)
        if (m_fr[i] == int'(sq_frame)) begin m_v[i] = 0; m_p1[i] = 0; m_p2[i] = 0; end
    if (win >= 0) begin m_v[win] = 0; m_p1[win] = 0; m_p2[win] = 0; end
    if (acc) begin
      if (op_pos) begin m_p2[s] = 1; m_b[s] = op_data; end
      else begin m_p1[s] = 1; m_a[s] = op_data; end
    end
    if (ld_en) begin
      s = int'(ld_slot);
      m_v[s] = 1; m_p1[s] = 0; m_p2[s] = 0;
      m_op[s] = int'(ld_opc); m_fr[s] = int'(ld_frame); m_nt[s] = int'(ld_ntgt);
      m_t0[s] = ld_tgt0; m_t1[s] = ld_tgt1;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin m_v[i] = 0; m_p1[i] = 0; m_p2[i] = 0; m_fr[i] = 0; end
      mp_v = 0; e_valid = 0; e_err = 0;
    end else model_step();
    if (cyc > 50000 && !done) begin
      done = 1; fails++;
      $display("FAIL watchdog actual=%0d expected=<50000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n && running) begin
    chk(cur_req, "res_valid", 64'(res_valid), 64'(e_valid));
    if (e_valid) begin
      chk(cur_req, "res_data", 64'(res_data), 64'(e_data));
      chk(cur_req, "res_target", 64'({res_row, res_col, res_slot, res_pos}), 64'(e_tgt));
    end
    chk(cur_req, "op_err", 64'(op_err), 64'(e_err));
  end

  function automatic logic [TGW-1:0] mk(int r, int c, int s, int p);
    return {OW'(r), OW'(c), SLW'(s), 1'(p)};
  endfunction

  task automatic tick();
    @(negedge clk);
    ld_en = 0; op_en = 0; sq_en = 0;
  endtask
  task automatic idle(int n);
    repeat (n) tick();
  endtask
  task automatic ld(int s, int o, int f, int n, logic [TGW-1:0] x, logic [TGW-1:0] y);
    ld_en = 1; ld_slot = SLW'(s); ld_opc = 3'(o); ld_frame = FW'(f);
    ld_ntgt = 2'(n); ld_tgt0 = x; ld_tgt1 = y;
  endtask
  task automatic opnd(int s, int p, logic [31:0] d);
    op_en = 1; op_slot = SLW'(s); op_pos = 1'(p); op_data = d;
  endtask
  task automatic sq(int f);
    sq_en = 1; sq_frame = FW'(f);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "res_valid after reset", 64'(res_valid), 64'd0);
    chk("R1", "op_err after reset", 64'(op_err), 64'd0);
    running = 1;

    // R5 every opcode, R3 operand storage, R2 load
    cur_req = "R5";
    for (int k = 0; k < 8; k++) begin
      ld(k, k, 0, 1, mk(1, -1, k + 8, k & 1), mk(0, 0, 0, 0)); tick();
      opnd(k, 0, 32'hF0F0_1234 + k); tick();
      if (k < 5) begin opnd(k, 1, 32'h0FF0_8765 * (k + 1)); tick(); end
      idle(2);
    end
    // R2 overwrite a partially filled slot
    cur_req = "R2";
    ld(9, 0, 1, 1, mk(-1, 0, 3, 1), 0); tick();
    opnd(9, 0, 32'd77); tick();
    ld(9, 5, 1, 1, mk(2, 3, 4, 0), 0); tick();
    opnd(9, 1, 32'd5); tick();
    opnd(9, 0, 32'd99); tick(); idle(2);

    // R4 lowest ready slot wins while second packet blocks issue
    cur_req = "R4";
    ld(20, 5, 0, 2, mk(1, 0, 1, 0), mk(1, 1, 2, 1)); tick();
    ld(6, 5, 0, 1, mk(0, 1, 6, 0), 0); tick();
    ld(2, 5, 0, 1, mk(0, -1, 2, 0), 0); tick();
    opnd(20, 0, 32'hAAAA_0001); tick();
    opnd(6, 0, 32'h6666); tick();
    opnd(2, 0, 32'h2222); tick();
    idle(4);

    // R6 target counts 0 and 3
    cur_req = "R6";
    ld(21, 0, 0, 0, mk(1, 1, 1, 1), 0); tick();
    opnd(21, 0, 1); tick(); opnd(21, 1, 2); tick(); idle(2);
    ld(22, 4, 0, 3, mk(-4, 3, 31, 1), mk(3, -4, 0, 0)); tick();
    opnd(22, 0, 32'hFFFF_0000); tick(); opnd(22, 1, 32'h00FF_FF00); tick(); idle(3);

    // R9 rejected operands
    cur_req = "R9";
    opnd(25, 0, 32'd1); tick();
    ld(25, 1, 0, 1, mk(0, 1, 0, 0), 0); tick();
    opnd(25, 0, 32'd100); tick();
    opnd(25, 0, 32'd555); tick();
    ld(26, 6, 0, 1, mk(0, 1, 1, 0), 0); tick();
    opnd(26, 1, 32'd9); tick();
    opnd(25, 1, 32'd30); tick();
    opnd(26, 0, 32'd44); tick(); idle(2);

    // R7 squash whole frame, other frame survives
    cur_req = "R7";
    ld(10, 0, 1, 1, mk(1, 0, 0, 0), 0); tick();
    ld(11, 2, 1, 1, mk(1, 0, 1, 0), 0); tick();
    ld(12, 3, 2, 1, mk(1, 0, 2, 0), 0); tick();
    opnd(10, 0, 32'd1); tick(); opnd(11, 0, 32'd2); tick(); opnd(12, 0, 32'd3); tick();
    sq(1); tick();
    opnd(10, 1, 32'd4); tick(); opnd(11, 1, 32'd5); tick(); opnd(12, 1, 32'd6); tick(); idle(2);
    // R7 squash in the cycle a slot became ready
    ld(13, 5, 1, 1, mk(0, 0, 13, 0), 0); tick();
    ld(14, 5, 2, 1, mk(0, 0, 14, 0), 0); tick();
    ld(15, 5, 2, 1, mk(0, 0, 15, 0), 0); tick();
    opnd(15, 0, 32'h15); tick(); idle(1);
    opnd(13, 0, 32'h13); tick();
    opnd(14, 0, 32'h14); sq(1); tick(); idle(3);
    // R7 squash drops pending second packet
    ld(16, 5, 3, 2, mk(1, 1, 1, 1), mk(2, 2, 2, 0)); tick();
    opnd(16, 0, 32'hBEEF); tick(); tick();
    sq(3); tick(); idle(2);

    // R8 operand coinciding with squash of its slot
    cur_req = "R8";
    ld(17, 0, 2, 1, mk(0, 1, 0, 1), 0); tick();
    opnd(17, 0, 32'd8); tick();
    opnd(17, 1, 32'd9); sq(2); tick();
    opnd(17, 1, 32'd9); tick(); idle(2);

    // R10 load with squash of its frame, load over a firing slot
    cur_req = "R10";
    ld(18, 0, 0, 1, mk(1, 2, 3, 0), 0); sq(0); tick();
    opnd(18, 0, 32'd40); tick(); opnd(18, 1, 32'd2); tick(); idle(2);
    ld(19, 5, 1, 1, mk(0, 3, 1, 0), 0); tick();
    opnd(19, 0, 32'h1919); tick();
    ld(19, 1, 1, 1, mk(0, 3, 2, 1), 0); tick();
    opnd(19, 0, 32'd50); tick(); opnd(19, 1, 32'd8); tick(); idle(3);

    // R4 mixed random traffic on a few slots and frames
    cur_req = "R4";
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 3) == 0)
        ld($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 3),
           TGW'($urandom), TGW'($urandom));
      if ($urandom_range(0, 1) == 0)
        opnd($urandom_range(0, 7), $urandom_range(0, 1), $urandom);
      if ($urandom_range(0, 15) == 0) sq($urandom_range(0, 3));
      tick();
    end
    idle(4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule